// File: doc/BRIEF.md
# Processor Trace Nibble Output Unit

This unit sits between a processor pipeline and a real-time debug trace port. Each clock the pipeline presents one event for the instruction that is retiring. The unit turns the event into a 4-bit status code on `pst`. For a jump whose target comes from a register, it can also capture the target address. A captured value is written into a 16-entry nibble FIFO as a size marker followed by its data nibbles, least significant nibble first. The FIFO drains onto the 4-bit `ddata` bus at one nibble per clock.

Because of the FIFO, status keeps flowing for later instructions while earlier captured data is still leaving on `ddata`. A capture is accepted only when the FIFO has room for the marker and every data nibble. When it has no room, the unit refuses the event and raises `stall` one clock later, with `pst` showing the idle code 0x0. The pipeline must then hold the same event until the unit accepts it.

The controller is a two-state machine. `ST_FLOW` is the state after an accepted event. `ST_HELD` is the state after a refused one. Two transitions exist. *refuse* moves FLOW→HELD, or stays in HELD, when a capture finds too little room. *accept* moves HELD→FLOW, or stays in FLOW, when it does not.

Top module: `trace_nibble_port`

## Requirements
- R1: While `rst` is high and after the first clock edge of reset, `pst`=0x0, `ddata`=0x0, `stall`=0 and the FIFO is empty.
- R2: Event kinds (`ev_kind`): 1 = sequential instruction, shown on `pst` as 0x1. 2 = direct taken branch, shown as 0x5. 3 = register-target jump, shown as 0x5. Kinds 0 and 4–7 are idle, shown as 0x0. `pst` shows the code at the clock edge on which the event is sampled.
- R3: For a kind-3 event, `cap_sel` selects the capture: 0 = none; 1 = 2 bytes, marker 0x9 plus 4 nibbles; 2 = 3 bytes, marker 0xA plus 6 nibbles; 3 = 4 bytes, marker 0xB plus 8 nibbles. Other kinds capture nothing.
- R4: The data nibbles follow the marker from least to most significant: bits 3:0, then 7:4, and so on. Address bits above the selected size are ignored.
- R5: `ddata` leaves the FIFO at one nibble per edge whenever the FIFO held data before that edge, and shows 0x0 otherwise. A capture written into an empty FIFO shows its marker one edge after the edge that accepted it.
- R6: `pst` reports later events while earlier captured nibbles are still draining.
- R7: A capture is accepted only if the free entries (16 minus the fill before that edge's read) number at least 1 plus its data nibbles. No capture is ever written in part, and the fill never exceeds 16.
- R8: A refused capture makes `stall`=1 and `pst`=0x0 after that edge and writes nothing. Once the held event is accepted, `stall` returns to 0 and `pst` shows 0x5.
- R9: Only kind 3 with a nonzero `cap_sel` can be refused. All other events are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_kind | input | 3 | Event for the retiring instruction |
| ev_addr | input | 32 | Jump target for a kind-3 capture |
| cap_sel | input | 2 | Capture size for register-target jumps |
| pst | output | 4 | Registered status code |
| ddata | output | 4 | Registered data nibble: marker or value |
| stall | output | 1 | Registered: the last event was refused and must be held |

## Verification
`pst` and `stall` are due one edge after an event is presented. `ddata` carries the head nibble one edge after it was queued, so a capture into an empty FIFO shows its marker two edges after the event was presented. The bench drives on the falling edge and keeps a nibble queue model. Before each rising edge it computes room from the queue size before the pop, then pops and pushes. It compares all three outputs on the next falling edge. A separate parser rebuilds each value from the `ddata` stream and matches it against the values that were accepted.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int NIB_W   = 4;
    localparam int ADDR_W  = 32;
    localparam int MAX_NIB = 1 + ADDR_W / NIB_W;   // marker + widest value
    localparam int LEN_W   = $clog2(MAX_NIB + 1);

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_SEQ  = 3'd1,
        EV_BRA  = 3'd2,
        EV_JREG = 3'd3
    } ev_kind_t;

    localparam logic [3:0] ST_IDLE  = 4'h0;
    localparam logic [3:0] ST_NEXT  = 4'h1;
    localparam logic [3:0] ST_TAKEN = 4'h5;

    // marker 0x8 + size code, data nibbles = 2 * (size + 1)
    function automatic logic [3:0] marker_of(input logic [1:0] sel);
        return 4'h8 + {2'b00, sel};
    endfunction

    function automatic logic [LEN_W-1:0] len_of(input logic [1:0] sel);
        return LEN_W'(2 * int'(sel) + 3);
    endfunction

endpackage

// File: rtl/trace_event_decode.sv
module trace_event_decode
    import trace_pkg::*;
(
    input  logic [2:0] kind,
    input  logic [1:0] cap_sel,
    output logic [3:0] status,
    output logic       want_cap
);
    always_comb begin
        status   = ST_IDLE;
        want_cap = 1'b0;
        unique case (kind)
            EV_SEQ:  status = ST_NEXT;
            EV_BRA:  status = ST_TAKEN;
            EV_JREG: begin
                status   = ST_TAKEN;
                want_cap = (cap_sel != 2'd0);
            end
            default: status = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/trace_capture_pack.sv
module trace_capture_pack
    import trace_pkg::*;
(
    input  logic [1:0]               cap_sel,
    input  logic [ADDR_W-1:0]        addr,
    output logic [MAX_NIB*NIB_W-1:0] nibs,
    output logic [LEN_W-1:0]         len
);
    localparam int DATA_NIB = MAX_NIB - 1;

    assign len = len_of(cap_sel);
    assign nibs[NIB_W-1:0] = marker_of(cap_sel);

    for (genvar i = 0; i < DATA_NIB; i++) begin : g_nib
        assign nibs[(i+1)*NIB_W +: NIB_W] = addr[i*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/trace_nibble_fifo.sv
module trace_nibble_fifo #(
    parameter int DEPTH = 16,   // power of two
    parameter int MAXW  = 9,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = $clog2(MAXW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LW-1:0]     wr_n,
    input  logic [MAXW*4-1:0] wr_nibs,
    input  logic              rd,
    output logic [3:0]        head,
    output logic [CW-1:0]     fill
);
    logic [3:0]    mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            for (int i = 0; i < MAXW; i++) begin
                if (LW'(i) < wr_n)
                    mem[wp + PW'(i)] <= wr_nibs[i*4 +: 4];
            end
            wp  <= wp + PW'(wr_n);
            if (rd) rp <= rp + 1'b1;
            cnt <= cnt + CW'(wr_n) - CW'(rd);
        end
    end

    assign head = mem[rp];
    assign fill = cnt;
endmodule

// File: rtl/trace_nibble_port.sv
module trace_nibble_port
    import trace_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [1:0]        cap_sel,
    output logic [3:0]        pst,
    output logic [3:0]        ddata,
    output logic              stall
);
    typedef enum logic {ST_FLOW, ST_HELD} port_state_t;

    port_state_t              state_q, state_d;
    logic [3:0]               status;
    logic                     want_cap;
    logic [MAX_NIB*NIB_W-1:0] nibs;
    logic [LEN_W-1:0]         len;
    logic [CW-1:0]            fill;
    logic [3:0]               head;
    logic                     refuse;
    logic [LEN_W-1:0]         wr_n;
    logic                     rd;
    logic [3:0]               pst_q, dd_q;

    trace_event_decode u_dec (
        .kind(ev_kind), .cap_sel(cap_sel), .status(status), .want_cap(want_cap)
    );

    trace_capture_pack u_pack (
        .cap_sel(cap_sel), .addr(ev_addr), .nibs(nibs), .len(len)
    );

    trace_nibble_fifo #(.DEPTH(DEPTH), .MAXW(MAX_NIB)) u_fifo (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_nibs(nibs),
        .rd(rd), .head(head), .fill(fill)
    );

    // room is judged on the fill before this edge's read
    always_comb begin
        refuse = want_cap && ((DEPTH - int'(fill)) < int'(len));
        wr_n   = (want_cap && !refuse) ? len : '0;
        rd     = (fill != '0);
        state_d = refuse ? ST_HELD : ST_FLOW;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FLOW;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pst_q <= ST_IDLE;
            dd_q  <= 4'h0;
        end else begin
            unique case (state_d)
                ST_HELD: pst_q <= ST_IDLE;
                ST_FLOW: pst_q <= status;
            endcase
            dd_q <= rd ? head : 4'h0;
        end
    end

    assign pst   = pst_q;
    assign ddata = dd_q;
    assign stall = (state_q == ST_HELD);
endmodule

// File: rtl/trace_port_chk.sv
module trace_port_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    ev_kind,
    input logic [1:0]    cap_sel,
    input logic [3:0]    pst,
    input logic [3:0]    ddata,
    input logic          stall,
    input logic [CW-1:0] fill
);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= DEPTH);

    assert_stall_idle_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> pst == 4'h0);

    assert_stall_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> fill <= $past(fill));

    assert_only_jreg_stalls_R9: assert property (@(posedge clk) disable iff (rst)
        !(ev_kind == 3'd3 && cap_sel != 2'd0) |=> !stall);

    assert_idle_kind_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 3'd0 || ev_kind > 3'd3) |=> pst == 4'h0);

    assert_empty_ddata_R5: assert property (@(posedge clk) disable iff (rst)
        fill == '0 |=> ddata == 4'h0);

    assert_marker_first_R3: assert property (@(posedge clk) disable iff (rst)
        (fill != '0 && $past(fill) == '0) |=>
            (ddata == 4'h9 || ddata == 4'hA || ddata == 4'hB));
endmodule

bind trace_nibble_port trace_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .cap_sel(cap_sel),
    .pst(pst), .ddata(ddata), .stall(stall), .fill(fill)
);

// File: tb/sim_trace_nibble_port.sv
module sim_trace_nibble_port;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  ev_kind;
    logic [31:0] ev_addr;
    logic [1:0]  cap_sel;
    logic [3:0]  pst, ddata;
    logic        stall;

    always #5 clk = ~clk;

    trace_nibble_port u0 (
        .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_addr(ev_addr),
        .cap_sel(cap_sel), .pst(pst), .ddata(ddata), .stall(stall)
    );

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic [3:0]  q[$];
    int unsigned vals[$];
    logic [3:0]  exp_pst, exp_dd;
    logic        exp_stall;
    logic        held;

    int          p_mode = 0, p_len = 0, p_idx = 0;
    int unsigned p_acc = 0;

    function automatic logic [3:0] status_of(input logic [2:0] k);
        case (k)
            3'd1:       return 4'h1;
            3'd2, 3'd3: return 4'h5;
            default:    return 4'h0;
        endcase
    endfunction

    function automatic int unsigned mask_of(input logic [1:0] s);
        case (s)
            2'd1:    return 32'h0000FFFF;
            2'd2:    return 32'h00FFFFFF;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model the edge that follows the current inputs (R2,R3,R5,R7,R8,R9)
    task automatic model_edge();
        int need;
        logic refuse;
        need = (ev_kind == 3'd3 && cap_sel != 0) ? 2 * int'(cap_sel) + 3 : 0;
        refuse = (need != 0) && (16 - q.size() < need);
        exp_dd = 4'h0;
        if (q.size() > 0) exp_dd = q.pop_front();
        exp_stall = refuse;
        exp_pst   = refuse ? 4'h0 : status_of(ev_kind);
        if (need != 0 && !refuse) begin
            q.push_back(4'h8 + {2'b00, cap_sel});
            for (int i = 0; i < need - 1; i++) q.push_back(ev_addr[i*4 +: 4]);
            vals.push_back(ev_addr & mask_of(cap_sel));
        end
        held = refuse;
    endtask

    // rebuild captured values from the ddata stream (R3, R4)
    task automatic parse(input logic [3:0] d);
        if (p_mode == 0) begin
            if (d >= 4'h9 && d <= 4'hB) begin
                p_len = 2 * (int'(d) - 8) + 2;
                p_acc = 0; p_idx = 0; p_mode = 1;
            end else if (d != 4'h0) begin
                chk("R3 marker", {28'd0, d}, 32'h9);
            end
        end else begin
            p_acc |= int'(d) << (4 * p_idx);
            p_idx++;
            if (p_idx == p_len) begin
                p_mode = 0;
                if (vals.size() == 0) chk("R4 value rebuilt", p_acc, 32'hDEAD_BEEF);
                else chk("R4 value rebuilt", p_acc, vals.pop_front());
            end
        end
    endtask

    task automatic step();
        model_edge();
        @(negedge clk);
        cycles++;
        chk("R2/R8 pst",  {28'd0, pst}, {28'd0, exp_pst});
        chk("R5 ddata",   {28'd0, ddata}, {28'd0, exp_dd});
        chk("R8 stall",   {31'd0, stall}, {31'd0, exp_stall});
        parse(ddata);
    endtask

    task automatic drive(input logic [2:0] k, input logic [31:0] a, input logic [1:0] s);
        ev_kind = k; ev_addr = a; cap_sel = s;
        step();
        while (held) step();   // pipeline holds a refused event (R8)
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; ev_kind = 3'd0; ev_addr = '0; cap_sel = 2'd1; held = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pst reset", {28'd0, pst}, 32'h0);
        chk("R1 ddata reset", {28'd0, ddata}, 32'h0);
        chk("R1 stall reset", {31'd0, stall}, 32'h0);
        rst = 1'b0;

        // directed: each size into an empty FIFO (R3, R4, R5)
        drive(3'd3, 32'h1234_ABCD, 2'd1);
        drive(3'd1, 32'h0, 2'd1);
        chk("R5 marker one edge after accept", {28'd0, ddata}, 32'h9);
        for (int i = 0; i < 10; i++) drive(3'd0, 32'h0, 2'd1);
        drive(3'd3, 32'hCAFE_F00D, 2'd2);
        for (int i = 0; i < 8; i++) drive(3'd2, 32'h0, 2'd2);   // R6 pst flows
        drive(3'd3, 32'h8765_4321, 2'd3);
        drive(3'd3, 32'h5555_5555, 2'd0);                       // R3 no capture
        for (int i = 0; i < 12; i++) drive(3'd0, 32'h0, 2'd0);
        chk("R7 fifo drained", q.size(), 0);

        // directed: fill back to back until refused (R7, R8)
        for (int i = 0; i < 5; i++) drive(3'd3, 32'h0000_1111 * (i + 1), 2'd3);
        // R9: other kinds never stall even when full
        for (int i = 0; i < 4; i++) drive(3'd7 - 3'(i), 32'hFFFF_FFFF, 2'd3);
        for (int i = 0; i < 20; i++) drive(3'd0, 32'h0, 2'd0);

        // constrained random
        for (int n = 0; n < 2500; n++) begin
            logic [2:0] k;
            int r;
            r = int'($urandom_range(0, 9));
            k = (r < 5) ? 3'd3 : 3'($urandom_range(0, 7));
            drive(k, $urandom, 2'($urandom_range(0, 3)));
        end
        for (int i = 0; i < 20; i++) drive(3'd0, 32'h0, 2'd0);
        chk("R4 all values seen", vals.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule